// File: doc/BRIEF.md
# Streaming Packet Framing and Stall Monitor

This block watches the transmit side of a packet-streaming link from the outside. The link carries valid, ready, start-of-packet and end-of-packet signals. The monitor only listens and never drives any of them. It checks that start and end markers pair up correctly and that no marker appears without valid. It also watches how long the sink keeps ready low. A stall of more than a set number of cycles raises a flag that can serve as a logic-analyser trigger.

To help find the cause of a hang after the trigger fires, the monitor keeps a short circular record of recent framing events. The record has enough depth for the start and end beats of the last two multi-beat packets. Each entry holds a cycle timestamp and the kind of marker seen. An index input selects which entry to read, counting back from the newest.

All flags are sticky until a synchronous reset or a clear pulse. Each framing error also has a one-cycle pulse that marks the cycle in which its flag first sets.

Top module: `stream_frame_monitor`

## Requirements
- R1: A beat is accepted only in a cycle where mon_valid and mon_ready are both high. Markers in any other cycle do not change the framing state, the history, or the duplicate-start and orphan-end flags.
- R2: An accepted start while a packet is open sets err_flags bit 0 (duplicate start).
- R3: An accepted end with no open packet, and without a start in the same beat, sets err_flags bit 1 (orphan end).
- R4: mon_sop or mon_eop high in a cycle where mon_valid is low sets err_flags bit 2. This applies whatever the level of mon_ready.
- R5: A beat with start and end together is a legal one-beat packet. It leaves no packet open afterwards.
- R6: The error flags and stall_flag are sticky. They clear only on rst or on clr. If clr and a detection fall in the same cycle, clr wins.
- R7: err_pulse bit i is high for exactly the one cycle in which err_flags bit i goes from 0 to 1. Repeat errors while the flag is set give no pulse.
- R8: stall_flag sets after mon_ready has been low for more than STALL_LIMIT (default 100) consecutive cycles, so 100 low cycles are not enough. Any cycle with ready high restarts the count. The count saturates, so the flag is raised again after a clr during a stall that continues.
- R9: Every accepted beat that carries a marker writes one history entry. The entry holds the timestamp and a kind field: bit 0 is start and bit 1 is end, so 3 means both. The buffer is a HIST_DEPTH (default 4) deep circular buffer.
- R10: History readout is registered. It shows the entry hist_idx positions back from the newest (0 is the newest), one cycle after hist_idx is presented. An entry that has not yet been written reads as hist_valid 0 with kind and stamp 0.
- R11: The timestamp is 0 in the first cycle after reset and then counts up by one every cycle.
- R12: After reset every flag and pulse is 0, no packet is open and the history is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Clears error and stall flags |
| mon_valid | input | 1 | Observed valid |
| mon_ready | input | 1 | Observed ready |
| mon_sop | input | 1 | Observed start-of-packet |
| mon_eop | input | 1 | Observed end-of-packet |
| hist_idx | input | $clog2(HIST_DEPTH) | History entry to read, 0 = newest |
| err_flags | output | 3 | Sticky errors: bit0 duplicate start, bit1 orphan end, bit2 marker without valid |
| err_pulse | output | 3 | First-occurrence pulse per error bit |
| stall_flag | output | 1 | Sticky ready-stall flag |
| hist_valid | output | 1 | Selected history entry has been written |
| hist_kind | output | 2 | Marker kind of the selected entry |
| hist_stamp | output | TS_W | Timestamp of the selected entry |

## Verification
The stall watchdog and the valid-with-marker check can both fire on the same clock edge. The bench provokes this by holding ready low for STALL_LIMIT cycles and then, on the next low-ready cycle, raising start with valid low. It then expects stall_flag, err_flags bit 2 and err_pulse bit 2 to rise together in one cycle, with neither event hiding the other. The same cycle-accurate reference model in the bench also judges a clear that lands during a saturated stall, where the flag must return on the very next cycle.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

  localparam int ERR_DUP     = 0;
  localparam int ERR_ORPHAN  = 1;
  localparam int ERR_NOVALID = 2;
  localparam int ERR_N       = 3;

  typedef enum logic [1:0] {
    MK_NONE = 2'b00,
    MK_SOP  = 2'b01,
    MK_EOP  = 2'b10,
    MK_BOTH = 2'b11
  } mark_t;

endpackage

// File: rtl/sfm_framing.sv
module sfm_framing
  import sfm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             valid,
  input  logic             ready,
  input  logic             sop,
  input  logic             eop,
  output logic [ERR_N-1:0] err_flags,
  output logic [ERR_N-1:0] err_pulse
);

  logic             open_q;
  logic             acc;
  logic [ERR_N-1:0] det;

  assign acc = valid & ready;

  always_comb begin
    det              = '0;
    det[ERR_DUP]     = acc & sop & open_q;
    det[ERR_ORPHAN]  = acc & eop & ~sop & ~open_q;
    det[ERR_NOVALID] = (sop | eop) & ~valid;
  end

  // packet open tracking: only accepted beats move it
  always_ff @(posedge clk) begin
    if (rst)
      open_q <= 1'b0;
    else if (acc && (sop || eop))
      open_q <= sop & ~eop;
  end

  for (genvar i = 0; i < ERR_N; i++) begin : g_err
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        err_flags[i] <= 1'b0;
        err_pulse[i] <= 1'b0;
      end else begin
        err_flags[i] <= err_flags[i] | det[i];
        err_pulse[i] <= det[i] & ~err_flags[i];
      end
    end
  end

endmodule

// File: rtl/sfm_stall.sv
module sfm_stall #(
  parameter int STALL_LIMIT = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic ready,
  output logic stall_flag
);

  localparam int             CW  = $clog2(STALL_LIMIT + 1);
  localparam logic [CW-1:0]  LIM = CW'(STALL_LIMIT);

  logic [CW-1:0] lo_cnt;
  logic          hit;

  // saturating count of consecutive low-ready cycles
  always_ff @(posedge clk) begin
    if (rst || ready)
      lo_cnt <= '0;
    else if (lo_cnt != LIM)
      lo_cnt <= lo_cnt + 1'b1;
  end

  assign hit = ~ready & (lo_cnt == LIM);

  always_ff @(posedge clk) begin
    if (rst || clr)
      stall_flag <= 1'b0;
    else if (hit)
      stall_flag <= 1'b1;
  end

endmodule

// File: rtl/sfm_history.sv
module sfm_history #(
  parameter int DEPTH = 4,
  parameter int TS_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [1:0]               wr_kind,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic                     rd_valid,
  output logic [1:0]               rd_kind,
  output logic [TS_W-1:0]          rd_stamp
);

  localparam int               PTR_W   = $clog2(DEPTH);
  localparam int               ENTRY_W = TS_W + 2;
  localparam logic [PTR_W:0]   FULL    = (PTR_W + 1)'(DEPTH);
  localparam logic [PTR_W-1:0] ONE     = PTR_W'(1);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wp;
  logic [PTR_W:0]     fill;
  logic [TS_W-1:0]    ts_q;
  logic [PTR_W-1:0]   rd_addr;
  logic [ENTRY_W-1:0] rd_q;
  logic               hv_q;

  always_ff @(posedge clk) begin
    if (rst)
      ts_q <= '0;
    else
      ts_q <= ts_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      fill <= '0;
    end else if (wr_en) begin
      wp <= wp + 1'b1;
      if (fill != FULL)
        fill <= fill + 1'b1;
    end
  end

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_en)
      mem[wp] <= {ts_q, wr_kind};
  end

  assign rd_addr = wp - ONE - rd_idx;

  always_ff @(posedge clk) begin
    rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst)
      hv_q <= 1'b0;
    else
      hv_q <= ({1'b0, rd_idx} < fill);
  end

  assign rd_valid = hv_q;
  assign rd_kind  = hv_q ? rd_q[1:0]         : 2'b00;
  assign rd_stamp = hv_q ? rd_q[ENTRY_W-1:2] : '0;

endmodule

// File: rtl/stream_frame_monitor.sv
module stream_frame_monitor
  import sfm_pkg::*;
#(
  parameter int STALL_LIMIT = 100,
  parameter int HIST_DEPTH  = 4,
  parameter int TS_W        = 16,
  localparam int IDX_W      = $clog2(HIST_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             mon_valid,
  input  logic             mon_ready,
  input  logic             mon_sop,
  input  logic             mon_eop,
  input  logic [IDX_W-1:0] hist_idx,
  output logic [ERR_N-1:0] err_flags,
  output logic [ERR_N-1:0] err_pulse,
  output logic             stall_flag,
  output logic             hist_valid,
  output logic [1:0]       hist_kind,
  output logic [TS_W-1:0]  hist_stamp
);

  mark_t beat_mark;
  logic  mark_wr;

  assign beat_mark = mark_t'({mon_eop, mon_sop});
  assign mark_wr   = mon_valid & mon_ready & (beat_mark != MK_NONE);

  sfm_framing u_framing (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .valid     (mon_valid),
    .ready     (mon_ready),
    .sop       (mon_sop),
    .eop       (mon_eop),
    .err_flags (err_flags),
    .err_pulse (err_pulse)
  );

  sfm_stall #(
    .STALL_LIMIT (STALL_LIMIT)
  ) u_stall (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .ready      (mon_ready),
    .stall_flag (stall_flag)
  );

  sfm_history #(
    .DEPTH (HIST_DEPTH),
    .TS_W  (TS_W)
  ) u_history (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (mark_wr),
    .wr_kind  (beat_mark),
    .rd_idx   (hist_idx),
    .rd_valid (hist_valid),
    .rd_kind  (hist_kind),
    .rd_stamp (hist_stamp)
  );

endmodule

// File: rtl/stream_frame_monitor_chk.sv
module stream_frame_monitor_chk #(
  parameter int STALL_LIMIT = 100
) (
  input logic       clk,
  input logic       rst,
  input logic       clr,
  input logic       mon_valid,
  input logic       mon_ready,
  input logic       mon_sop,
  input logic       mon_eop,
  input logic [2:0] err_flags,
  input logic [2:0] err_pulse,
  input logic       stall_flag
);

  localparam int            LW  = $clog2(STALL_LIMIT + 2);
  localparam logic [LW-1:0] LIM = LW'(STALL_LIMIT);

  logic [LW-1:0] lo_seen;

  always_ff @(posedge clk) begin
    if (rst || mon_ready)
      lo_seen <= '0;
    else if (lo_seen <= LIM)
      lo_seen <= lo_seen + 1'b1;
  end

  // R1
  framing_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!(mon_valid && mon_ready) && !clr) |=> (err_flags[1:0] == $past(err_flags[1:0])));

  // R4
  marker_novalid_chk: assert property (@(posedge clk) disable iff (rst)
    ((mon_sop || mon_eop) && !mon_valid && !clr) |=> err_flags[2]);

  // R6
  sticky_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  // R6
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (err_flags == 3'b000 && !stall_flag));

  // R7
  pulse_with_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (|err_pulse) |-> ((err_pulse & ~err_flags) == 3'b000));

  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    (|err_pulse) |=> ((err_pulse & $past(err_pulse)) == 3'b000));

  // R8
  stall_not_early_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stall_flag) |-> (lo_seen > LIM));

  // R8
  stall_fires_chk: assert property (@(posedge clk) disable iff (rst)
    (!mon_ready && lo_seen == LIM && !clr) |=> stall_flag);

endmodule

bind stream_frame_monitor stream_frame_monitor_chk #(
  .STALL_LIMIT (STALL_LIMIT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clr        (clr),
  .mon_valid  (mon_valid),
  .mon_ready  (mon_ready),
  .mon_sop    (mon_sop),
  .mon_eop    (mon_eop),
  .err_flags  (err_flags),
  .err_pulse  (err_pulse),
  .stall_flag (stall_flag)
);

// File: tb/test_stream_frame_monitor.sv
module test_stream_frame_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 100;
  localparam int DEPTH      = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr = 1'b0;
  logic        mon_valid = 1'b0;
  logic        mon_ready = 1'b1;
  logic        mon_sop = 1'b0;
  logic        mon_eop = 1'b0;
  logic [1:0]  hist_idx = 2'd0;
  logic [2:0]  err_flags;
  logic [2:0]  err_pulse;
  logic        stall_flag;
  logic        hist_valid;
  logic [1:0]  hist_kind;
  logic [15:0] hist_stamp;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stream_frame_monitor i_stream_frame_monitor (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .mon_valid  (mon_valid),
    .mon_ready  (mon_ready),
    .mon_sop    (mon_sop),
    .mon_eop    (mon_eop),
    .hist_idx   (hist_idx),
    .err_flags  (err_flags),
    .err_pulse  (err_pulse),
    .stall_flag (stall_flag),
    .hist_valid (hist_valid),
    .hist_kind  (hist_kind),
    .hist_stamp (hist_stamp)
  );

  typedef struct {
    string       req;
    logic [2:0]  err;
    logic [2:0]  pls;
    logic        stall;
    logic        hv;
    logic [1:0]  hk;
    logic [15:0] hs;
  } item_t;

  item_t sb[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  // reference model state, built from the requirements
  logic [2:0] m_err, m_pls;
  bit         m_stall, m_open;
  int         m_lo, m_mt, m_wp, m_fill;
  logic [1:0] m_hk [DEPTH];
  int         m_hs [DEPTH];

  task automatic do_reset();
    rst = 1'b1; clr = 1'b0; mon_valid = 1'b0; mon_ready = 1'b1;
    mon_sop = 1'b0; mon_eop = 1'b0; hist_idx = 2'd0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_err = '0; m_pls = '0; m_stall = 1'b0; m_open = 1'b0;
    m_lo = 0; m_mt = 0; m_wp = 0; m_fill = 0;
  endtask

  // driver: apply one cycle of stimulus, push the expected outcome
  task automatic step(input bit v, input bit r, input bit s, input bit e,
                      input bit c, input int idx, input string req);
    item_t      it;
    logic [2:0] det;
    bit         acc, hit;
    int         p;
    mon_valid = v; mon_ready = r; mon_sop = s; mon_eop = e;
    clr = c; hist_idx = idx[1:0];
    it.req = req;
    it.hv  = (idx < m_fill);
    if (it.hv) begin
      p     = (m_wp - 1 - idx + 2 * DEPTH) % DEPTH;
      it.hk = m_hk[p];
      it.hs = m_hs[p][15:0];
    end else begin
      it.hk = 2'b00;
      it.hs = 16'd0;
    end
    acc    = v && r;
    det[0] = acc && s && m_open;
    det[1] = acc && e && !s && !m_open;
    det[2] = (s || e) && !v;
    hit    = !r && (m_lo == LIMIT);
    if (acc && (s || e)) begin
      m_hk[m_wp] = {e, s};
      m_hs[m_wp] = m_mt;
      m_wp = (m_wp + 1) % DEPTH;
      if (m_fill < DEPTH) m_fill++;
      m_open = s && !e;
    end
    if (c) begin
      m_pls = '0; m_err = '0; m_stall = 1'b0;
    end else begin
      m_pls = det & ~m_err;
      m_err = m_err | det;
      m_stall = m_stall | hit;
    end
    m_lo = r ? 0 : ((m_lo < LIMIT) ? m_lo + 1 : m_lo);
    m_mt++;
    it.err = m_err; it.pls = m_pls; it.stall = m_stall;
    @(posedge clk);
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle(input int idx, input string req);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, idx, req);
  endtask

  // monitor: pop and compare half a cycle after each edge
  always @(negedge clk) begin
    if (!rst && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_chk++;
      if (err_flags !== it.err || err_pulse !== it.pls || stall_flag !== it.stall) begin
        n_fail++;
        $display("FAIL %s flags: err=%b pls=%b stall=%b expected err=%b pls=%b stall=%b",
                 it.req, err_flags, err_pulse, stall_flag, it.err, it.pls, it.stall);
      end
      n_chk++;
      if (hist_valid !== it.hv || hist_kind !== it.hk || hist_stamp !== it.hs) begin
        n_fail++;
        $display("FAIL %s history: v=%b kind=%b stamp=%0d expected v=%b kind=%b stamp=%0d",
                 it.req, hist_valid, hist_kind, hist_stamp, it.hv, it.hk, it.hs);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R12 reset state, R11 timestamp starts at zero
    idle(0, "R12 reset idle");
    idle(3, "R12 empty history");
    // R5 single-beat packet, R9 entry written, R10 readback
    step(1, 1, 1, 1, 0, 0, "R5 one-beat packet");
    idle(0, "R10 read newest");
    idle(0, "R11 stamp of one-beat packet");
    idle(1, "R10 unwritten entry");
    // R1 markers held under backpressure are not accepted
    step(1, 0, 1, 0, 0, 0, "R1 start under backpressure");
    step(1, 0, 1, 0, 0, 0, "R1 start still held");
    idle(0, "R1 history unchanged");
    // clean multi-beat packet
    step(1, 1, 1, 0, 0, 0, "R9 start beat");
    step(1, 1, 0, 0, 0, 0, "R1 payload beat");
    step(1, 0, 0, 1, 0, 0, "R1 end held");
    step(1, 1, 0, 1, 0, 0, "R9 end beat");
    idle(0, "R9 newest is end");
    idle(1, "R9 older is start");
    idle(2, "R9 oldest one-beat");
    // wrap the circular buffer
    step(1, 1, 1, 0, 0, 0, "R9 wrap start");
    step(1, 1, 0, 1, 0, 0, "R9 wrap end");
    for (int k = 0; k < DEPTH; k++) idle(k, "R9 after wrap");
    // R2 duplicate start, R7 single pulse
    step(1, 1, 1, 0, 0, 0, "R2 open");
    step(1, 1, 1, 0, 0, 0, "R2 duplicate start");
    idle(0, "R7 pulse gone");
    step(1, 1, 1, 1, 0, 0, "R7 repeat duplicate no pulse");
    // R6 clear, then clear against a same-cycle detection
    step(0, 1, 0, 0, 1, 0, "R6 clear flags");
    step(1, 1, 0, 1, 1, 0, "R6 clear wins over orphan");
    idle(0, "R6 still clear");
    // R3 orphan end and two ends in a row
    step(1, 1, 0, 1, 0, 0, "R3 orphan end");
    step(1, 1, 1, 0, 0, 0, "R3 open");
    step(1, 1, 0, 1, 0, 0, "R3 legal end");
    step(1, 1, 0, 1, 0, 1, "R3 second end");
    // R4 marker without valid, with and without ready
    step(0, 0, 0, 0, 1, 0, "R6 clear");
    step(0, 1, 1, 0, 0, 0, "R4 start without valid");
    step(0, 1, 0, 0, 1, 0, "R6 clear");
    step(0, 0, 0, 1, 0, 0, "R4 end without valid, ready low");
    idle(0, "R4 no history write");
    step(0, 1, 0, 0, 1, 0, "R6 clear");
    // R8 exactly LIMIT low cycles: no flag, then restart
    for (int k = 0; k < LIMIT; k++) step(0, 0, 0, 0, 0, 0, "R8 low within limit");
    idle(0, "R8 ready restarts count");
    for (int k = 0; k < LIMIT + 1; k++) step(0, 0, 0, 0, 0, 0, "R8 low past limit");
    for (int k = 0; k < 150; k++) step(0, 0, 0, 0, 0, 0, "R8 long stall stays set");
    step(0, 0, 0, 0, 1, 0, "R8 clear during stall");
    step(0, 0, 0, 0, 0, 0, "R8 saturated count refires");
    step(0, 1, 0, 0, 1, 0, "R6 clear all");
    // stall and framing error in the same edge
    for (int k = 0; k < LIMIT; k++) step(0, 0, 0, 0, 0, 0, "R8 approach");
    step(0, 0, 1, 0, 0, 0, "R8 R4 stall with marker error");
    idle(0, "R8 R4 both held");
    for (int k = 0; k < DEPTH; k++) idle(k, "R10 final history");
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule